// File: doc/BRIEF.md
# Incremental Phase Shift Controller

This block holds a signed phase offset, counted in units of one delay step, and moves it by a single step each time a request is accepted. A request is sampled in the phase-adjust clock domain: an enable qualifies the cycle and a direction input chooses whether the offset grows or shrinks. The current offset is presented as a plain signed value, meant to select a tap of an external delay line.

Each accepted adjustment must settle before another is taken. The settling wait is counted mostly in a separate reference-clock domain and ends with a short stage in the phase-adjust domain. At that point a one-cycle done pulse marks the unit as ready. Requests that arrive during the wait are dropped. The offset saturates at a symmetric limit derived at elaboration from the reference clock period. A reset held long enough returns the offset to zero.

Top module: `phase_step_ctrl`

## Requirements
- R1: With default polarities, a rising phase-adjust clock edge with `ps_en` high while idle accepts a request; `ps_dir` high increments the offset and low decrements it.
- R2: Each accepted request changes `step_ofs` by exactly one step, visible in the cycle after the accepting edge; the offset never moves by more than one step per cycle.
- R3: `ps_done` is high for exactly one phase-adjust clock cycle for each accepted request.
- R4: `ps_done` rises no earlier than `SETTLE_REF_CYC` reference cycles plus `PS_TAIL_CYC` phase-adjust cycles after the accepting edge.
- R5: A request made while an adjustment is in flight is ignored: the offset does not change and it produces no extra done pulse.
- R6: The offset stays within plus or minus floor(20 × (reference period in ns − 3)); with a 4 ns period the limit is 20.
- R7: A request that would move the offset past the limit leaves it unchanged but still completes with a done pulse.
- R8: Holding `rst_n` low for at least `RST_MIN_CYC` (3) reference cycles sets `step_ofs` to 0 and `ps_done` to 0.
- R9: A low pulse on `rst_n` shorter than `RST_MIN_CYC` reference cycles has no effect on the offset.
- R10: With the inversion parameters set, the enable is active low, a low direction increments, and requests are taken on the falling edge of `ps_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset request, qualified by a minimum length in the reference domain |
| ref_clk | input | 1 | Reference clock that times the main settling wait |
| ps_clk | input | 1 | Phase-adjust clock (polarity set by `INV_CLK`) |
| ps_en | input | 1 | Request enable (polarity set by `INV_EN`) |
| ps_dir | input | 1 | Step direction, increment when active (polarity set by `INV_DIR`) |
| ps_done | output | 1 | One-cycle pulse when an adjustment has completed |
| step_ofs | output | OFS_W | Current signed offset in delay steps |

## Verification
The bench builds the block with a 4 ns reference period, so the limit is 20. Both ends of the range, and the request that would pass each end, can then be reached within a few dozen steps. The settling parameters keep their defaults of 100 reference cycles and 3 phase-adjust cycles. The lower latency bound is therefore measured at its real size against a 5 ns phase-adjust clock. A second instance sets all three inversion parameters, so the inverted enable, inverted direction and falling-edge acceptance are exercised next to the default instance.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TAIL = 2'd2
  } ps_state_e;

  // Symmetric offset limit from the reference period given in picoseconds.
  function automatic int calc_limit(input int period_ps);
    if (period_ps <= 3000) return 0;
    return (20 * (period_ps - 3000)) / 1000;
  endfunction

endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
  parameter int MIN_LOW = 3
) (
  input  logic ref_clk,
  input  logic ps_ck,
  input  logic rst_n,
  output logic ref_rst_n,
  output logic ps_rst_n
);

  logic [1:0]         in_sync;
  logic [MIN_LOW-1:0] low_hist;
  logic               ref_rst_q;
  logic [1:0]         ps_sync;

  // Length filter: reset only after MIN_LOW consecutive low samples.
  always_ff @(posedge ref_clk) begin
    in_sync   <= {in_sync[0], rst_n};
    low_hist  <= {low_hist[MIN_LOW-2:0], ~in_sync[1]};
    ref_rst_q <= ~(&low_hist);
  end

  assign ref_rst_n = ref_rst_q;

  // Phase-adjust domain: asserted at once, released on its own clock.
  always_ff @(posedge ps_ck or negedge ref_rst_q) begin
    if (!ref_rst_q) ps_sync <= 2'b00;
    else            ps_sync <= {ps_sync[0], 1'b1};
  end

  assign ps_rst_n = ps_sync[1];

endmodule

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;
  logic [W-1:0] stab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      stab <= '0;
    end else begin
      meta <= d;
      stab <= meta;
    end
  end

  assign q = stab;

endmodule

// File: rtl/ref_settle_timer.sv
module ref_settle_timer #(
  parameter int SETTLE = 100
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic start_tgl,
  output logic ack_tgl
);

  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  logic          seen_q, seen_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;

  always_comb begin
    seen_d = seen_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ack_d  = ack_q;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        ack_d  = ~ack_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start_tgl != seen_q) begin
      seen_d = start_tgl;
      busy_d = 1'b1;
      cnt_d  = CW'(SETTLE - 1);
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
    end
  end

  assign ack_tgl = ack_q;

  // R4
  settle_count_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R4
  ack_only_at_end_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ack_q != $past(ack_q)) |-> ($past(busy_q) && $past(cnt_q) == '0));

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_step_pkg::*;
#(
  parameter int   REF_PERIOD_PS  = 10000,
  parameter int   SETTLE_REF_CYC = 100,
  parameter int   PS_TAIL_CYC    = 3,
  parameter int   RST_MIN_CYC    = 3,
  parameter logic INV_CLK        = 1'b0,
  parameter logic INV_EN         = 1'b0,
  parameter logic INV_DIR        = 1'b0,
  localparam int  LIMIT          = calc_limit(REF_PERIOD_PS),
  localparam int  OFS_W          = $clog2(LIMIT + 1) + 1
) (
  input  logic                    rst_n,
  input  logic                    ref_clk,
  input  logic                    ps_clk,
  input  logic                    ps_en,
  input  logic                    ps_dir,
  output logic                    ps_done,
  output logic signed [OFS_W-1:0] step_ofs
);

  localparam int TW = (PS_TAIL_CYC > 1) ? $clog2(PS_TAIL_CYC) : 1;
  localparam logic signed [OFS_W-1:0] LIM_P = OFS_W'(LIMIT);
  localparam logic signed [OFS_W-1:0] LIM_N = -LIM_P;
  localparam logic signed [OFS_W-1:0] ONE   = OFS_W'(1);

  logic ps_ck;
  logic en_i;
  logic dir_i;
  logic ref_rst_n;
  logic ps_rst_n;

  assign ps_ck = ps_clk ^ INV_CLK;
  assign en_i  = ps_en  ^ INV_EN;
  assign dir_i = ps_dir ^ INV_DIR;

  rst_qual #(.MIN_LOW(RST_MIN_CYC)) u_rst_qual (
    .ref_clk  (ref_clk),
    .ps_ck    (ps_ck),
    .rst_n    (rst_n),
    .ref_rst_n(ref_rst_n),
    .ps_rst_n (ps_rst_n)
  );

  ps_state_e               state_q, state_d;
  logic signed [OFS_W-1:0] ofs_q, ofs_d;
  logic                    req_tgl_q, req_tgl_d;
  logic                    ack_seen_q, ack_seen_d;
  logic [TW-1:0]           tail_q, tail_d;
  logic                    done_q, done_d;
  logic                    req_tgl_r;
  logic                    ack_tgl_r;
  logic                    ack_tgl_p;
  logic                    accept;

  sync_2ff #(.W(1)) u_req_sync (
    .clk  (ref_clk),
    .rst_n(ref_rst_n),
    .d    (req_tgl_q),
    .q    (req_tgl_r)
  );

  ref_settle_timer #(.SETTLE(SETTLE_REF_CYC)) u_settle (
    .ref_clk  (ref_clk),
    .rst_n    (ref_rst_n),
    .start_tgl(req_tgl_r),
    .ack_tgl  (ack_tgl_r)
  );

  sync_2ff #(.W(1)) u_ack_sync (
    .clk  (ps_ck),
    .rst_n(ps_rst_n),
    .d    (ack_tgl_r),
    .q    (ack_tgl_p)
  );

  assign accept = (state_q == ST_IDLE) && en_i;

  always_comb begin
    state_d    = state_q;
    ofs_d      = ofs_q;
    req_tgl_d  = req_tgl_q;
    ack_seen_d = ack_seen_q;
    tail_d     = tail_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dir_i && ofs_q != LIM_P)       ofs_d = ofs_q + ONE;
          else if (!dir_i && ofs_q != LIM_N) ofs_d = ofs_q - ONE;
          req_tgl_d = ~req_tgl_q;
          state_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ack_tgl_p != ack_seen_q) begin
          ack_seen_d = ack_tgl_p;
          tail_d     = TW'(PS_TAIL_CYC - 1);
          state_d    = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (tail_q == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tail_d = tail_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge ps_ck or negedge ps_rst_n) begin
    if (!ps_rst_n) begin
      state_q    <= ST_IDLE;
      ofs_q      <= '0;
      req_tgl_q  <= 1'b0;
      ack_seen_q <= 1'b0;
      tail_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      ofs_q      <= ofs_d;
      req_tgl_q  <= req_tgl_d;
      ack_seen_q <= ack_seen_d;
      tail_q     <= tail_d;
      done_q     <= done_d;
    end
  end

  assign ps_done  = done_q;
  assign step_ofs = ofs_q;

  // R2
  step_size_chk: assert property (@(posedge ps_ck) disable iff (!ps_rst_n)
    (ofs_q == $past(ofs_q)) || (ofs_q == $past(ofs_q) + ONE) || (ofs_q == $past(ofs_q) - ONE));

  // R3
  done_width_chk: assert property (@(posedge ps_ck) disable iff (!ps_rst_n)
    done_q |=> !done_q);

  // R5
  busy_hold_chk: assert property (@(posedge ps_ck) disable iff (!ps_rst_n)
    (state_q != ST_IDLE) |=> $stable(ofs_q));

  // R6
  ofs_range_chk: assert property (@(posedge ps_ck) disable iff (!ps_rst_n)
    (ofs_q <= LIM_P) && (ofs_q >= LIM_N));

endmodule

// File: tb/phase_step_ctrl_bench.sv
`timescale 1ns/1ps
module phase_step_ctrl_bench;

  localparam int REF_PS  = 4000;
  localparam int LIM     = 20;
  localparam int W       = 6;
  localparam int MIN_LAT = 83;
  localparam int MAX_LAT = 120;
  localparam int NVEC    = 8;
  localparam bit VEC_DIR [NVEC] = '{1, 1, 1, 0, 0, 0, 0, 0};
  localparam int VEC_EXP [NVEC] = '{1, 2, 3, 2, 1, 0, -1, -2};

  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic ps_clk = 1'b0;
  logic en = 1'b0, dir = 1'b0;
  logic en_b = 1'b1, dir_b = 1'b1;
  logic done, done_b;
  logic signed [W-1:0] ofs, ofs_b;

  int runs = 0, fails = 0;
  bit finished = 0;

  always #2.5 ps_clk = ~ps_clk;
  always #2   ref_clk = ~ref_clk;

  phase_step_ctrl #(.REF_PERIOD_PS(REF_PS)) u_phase_step_ctrl (
    .rst_n(rst_n), .ref_clk(ref_clk), .ps_clk(ps_clk),
    .ps_en(en), .ps_dir(dir), .ps_done(done), .step_ofs(ofs));

  phase_step_ctrl #(.REF_PERIOD_PS(REF_PS), .INV_CLK(1'b1), .INV_EN(1'b1), .INV_DIR(1'b1))
    u_phase_step_ctrl_inv (
    .rst_n(rst_n), .ref_clk(ref_clk), .ps_clk(ps_clk),
    .ps_en(en_b), .ps_dir(dir_b), .ps_done(done_b), .step_ofs(ofs_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_step(input bit up, output int first_ofs, output int lat,
                         output bit saw, output bit one_wide);
    @(negedge ps_clk); en = 1'b1; dir = up;
    @(negedge ps_clk); en = 1'b0;
    first_ofs = int'(ofs); lat = 1; saw = 1'b0; one_wide = 1'b0;
    while (lat < 400 && !saw) begin
      if (done) saw = 1'b1;
      else begin @(negedge ps_clk); lat++; end
    end
    if (saw) begin @(negedge ps_clk); one_wide = !done; end
  endtask

  task automatic full_check(input bit up, input int exp, input string tag);
    int f, l; bit s, w;
    do_step(up, f, l, s, w);
    chk(f == exp, {tag, " R2 offset"}, f, exp);
    chk(s, {tag, " R3 done seen"}, s, 1);
    chk(w, {tag, " R3 done one cycle"}, w, 1);
    chk(l >= MIN_LAT && l <= MAX_LAT, {tag, " R4 latency"}, l, MIN_LAT);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    int f, l, cnt; bit s, w;
    repeat (10) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (20) @(negedge ps_clk);
    // R8 reset state
    chk(ofs == 0, "R8 reset offset", int'(ofs), 0);
    chk(done == 1'b0, "R8 reset done", done, 0);

    // R1 R2 R3 R4 vector table
    for (int i = 0; i < NVEC; i++) full_check(VEC_DIR[i], VEC_EXP[i], "R1 table");

    // R5 request during busy is dropped
    @(negedge ps_clk); en = 1'b1; dir = 1'b1;
    @(negedge ps_clk); en = 1'b0;
    repeat (20) @(negedge ps_clk);
    en = 1'b1; dir = 1'b1;
    @(negedge ps_clk); en = 1'b0;
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge ps_clk);
      if (done) cnt++;
    end
    chk(ofs == -1, "R5 offset after busy request", int'(ofs), -1);
    chk(cnt == 1, "R5 done pulse count", cnt, 1);

    // R6 R7 upper limit
    for (int k = 0; k < LIM + 1; k++) do_step(1'b1, f, l, s, w);
    chk(ofs == LIM, "R6 upper limit reached", int'(ofs), LIM);
    do_step(1'b1, f, l, s, w);
    chk(f == LIM, "R7 held at upper limit", f, LIM);
    chk(s, "R7 done at upper limit", s, 1);

    // R6 R7 lower limit
    for (int k = 0; k < 2 * LIM; k++) do_step(1'b0, f, l, s, w);
    chk(ofs == -LIM, "R6 lower limit reached", int'(ofs), -LIM);
    do_step(1'b0, f, l, s, w);
    chk(f == -LIM, "R7 held at lower limit", f, -LIM);
    chk(s, "R7 done at lower limit", s, 1);

    // R10 inverted instance: enable low, direction low increments, falling edge
    @(posedge ps_clk); #0.5 en_b = 1'b0; dir_b = 1'b0;
    @(posedge ps_clk); #0.5 en_b = 1'b1;
    chk(ofs_b == 1, "R10 inverted increment", int'(ofs_b), 1);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(posedge ps_clk); #0.5;
      if (done_b) cnt++;
    end
    chk(cnt == 1, "R10 inverted done", cnt, 1);
    chk(ofs == -LIM, "R10 default instance untouched", int'(ofs), -LIM);

    // R9 short reset pulse ignored
    @(negedge ref_clk); rst_n = 1'b0;
    repeat (2) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (20) @(negedge ps_clk);
    chk(ofs == -LIM, "R9 short reset ignored", int'(ofs), -LIM);
    chk(ofs_b == 1, "R9 short reset ignored inv", int'(ofs_b), 1);

    // R8 long reset clears
    @(negedge ref_clk); rst_n = 1'b0;
    repeat (6) @(negedge ref_clk);
    @(negedge ps_clk);
    chk(ofs == 0, "R8 long reset offset", int'(ofs), 0);
    chk(done == 1'b0, "R8 long reset done", done, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge ps_clk);
    chk(ofs_b == 0, "R8 long reset inv offset", int'(ofs_b), 0);
    full_check(1'b1, 1, "R8 after reset");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

endmodule